// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block sends one reader-to-tag frame over a single carrier-enable line. Every data bit opens with a fixed carrier-off gap and is then carried by how long the whole bit period lasts: a long period means an encoded one, a short period an encoded zero. Before a bit is encoded it is XORed with the current bit from an external keystream generator. The block asks that generator to step once per bit, at the moment the gap ends. All timing is counted in pulses of a `tick` strobe, which comes from a shared timebase and can be sparser than the clock.

A frame word and its bit count arrive on a valid/ready stream. `frm_ready` is high only while the block is idle. A frame is taken in the cycle where `frm_valid` and `frm_ready` are both high. While `frm_ready` is low, `frm_valid` has no effect. The source may hold `frm_valid` and the frame fields steady for as long as it needs to wait. After the last bit the block sends one more gap as an end marker. It then raises the carrier, pulses `done`, and clears a free-running tick counter, so a receiver can time the tag reply from that point.

Top module: `ppm_frame_tx`

## Requirements
- R1: After reset the outputs are `carrier_en`=1, `busy`=0, `done`=0, `frm_ready`=1, and `reply_ticks`=0.
- R2: A frame is accepted only in a cycle with `frm_valid`=1 and `frm_ready`=1. `frm_ready` is 0 while `busy` is 1, and a `frm_valid` that is raised during that time changes nothing on any output.
- R3: Bits go out least significant bit first. Each bit begins with a carrier-off gap of 30 ticks. The first gap starts in the cycle after acceptance, and each later gap starts in the cycle after the previous bit ends. A tick in the acceptance cycle is not counted.
- R4: An encoded one lasts 150 ticks in total and an encoded zero lasts 90 ticks in total, gap included. After its gap the carrier stays on for the rest of the bit.
- R5: The encoded value is the frame bit XOR `ks_bit`. `ks_bit` is sampled in the cycle of the gap's 30th tick.
- R6: `ks_step` is high for exactly one cycle per bit: the cycle of the gap's 30th tick. At no other time is it high.
- R7: After the last bit, a 30-tick carrier-off end marker follows. Then the carrier returns high, `busy` falls, and `done` is high for one cycle.
- R8: `reply_ticks` is 0 in the cycle where `done` is high. After that it rises by one on each tick and saturates at its maximum value.
- R9: A bit count of 0 sends only the end marker. A bit count above DATA_W is treated as DATA_W.
- R10: Without a tick, a frame in progress does not advance: `carrier_en` holds and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one pulse per tick |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Block idle and able to accept a frame |
| frm_data | input | DATA_W | Frame bits, bit 0 sent first |
| frm_len | input | clog2(DATA_W)+2 | Number of bits to send |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | Advance the keystream by one step |
| carrier_en | output | 1 | Carrier enable, low during gaps |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame ends |
| reply_ticks | output | RPLY_W | Ticks since the last frame end, saturating |

## Verification
Two events can land in the same cycle. In the cycle where `done` pulses, a new frame can be accepted while `reply_ticks` is being cleared. The bench provokes this by holding `frm_valid` high through the end of a frame. The model then expects the counter at zero together with a carrier drop in the very next cycle. A tick can also arrive in the acceptance cycle itself. The bench runs tick patterns that put a tick on every cycle, so the model can check that such a tick does not shorten the first gap.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_MARK  = 2'd2,
    ST_EOF   = 2'd3
  } ppm_state_e;

endpackage

// File: rtl/ppm_tick_cnt.sv
module ppm_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/ppm_bit_shifter.sv
module ppm_bit_shifter #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              shift,
  output logic              cur_bit,
  output logic              last_bit,
  output logic              empty_in
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [LEN_W-1:0]  rem;
  logic [LEN_W-1:0]  eff_len;

  always_comb begin
    eff_len  = (len_in > MAX_LEN) ? MAX_LEN : len_in;
    empty_in = (len_in == '0);
    cur_bit  = sh[0];
    last_bit = (rem == LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      rem <= '0;
    end else if (load) begin
      sh  <= data_in;
      rem <= eff_len;
    end else if (shift) begin
      sh  <= sh >> 1;
      rem <= rem - LEN_W'(1);
    end
  end

  // R9: the loaded count never exceeds the word width
  p_len_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rem <= MAX_LEN));

endmodule

// File: rtl/ppm_reply_timer.sv
module ppm_reply_timer #(
  parameter int W        = 16,
  parameter bit SATURATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);

  logic at_top;
  logic bump;

  generate
    if (SATURATE) begin : g_sat
      assign at_top = &cnt;
    end else begin : g_wrap
      assign at_top = 1'b0;
    end
  endgenerate

  assign bump = tick && !at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (bump) cnt <= cnt + W'(1);
  end

  // R8: without a tick or a clear the reply counter holds
  p_reply_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/ppm_frame_tx.sv
module ppm_frame_tx
  import ppm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int T_PAUSE = 30,
  parameter int T_ONE   = 150,
  parameter int T_ZERO  = 90,
  parameter int RPLY_W  = 16,
  parameter int LEN_W   = $clog2(DATA_W) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [DATA_W-1:0] frm_data,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              ks_bit,
  output logic              ks_step,
  output logic              carrier_en,
  output logic              busy,
  output logic              done,
  output logic [RPLY_W-1:0] reply_ticks
);

  localparam int CNT_W = $clog2(T_ONE + 1);
  localparam logic [CNT_W-1:0] PAUSE_LAST = CNT_W'(T_PAUSE - 1);
  localparam logic [CNT_W-1:0] ONE_LAST   = CNT_W'(T_ONE - 1);
  localparam logic [CNT_W-1:0] ZERO_LAST  = CNT_W'(T_ZERO - 1);

  ppm_state_e       st, st_nx;
  logic [CNT_W-1:0] tcnt;
  logic             enc;
  logic             cur_bit, last_bit, empty_in;
  logic             accept, pause_end, mark_end, eof_end;
  logic             cnt_clr, cnt_inc;
  logic             done_q;

  always_comb begin
    frm_ready  = (st == ST_IDLE);
    accept     = frm_valid && frm_ready;
    pause_end  = tick && (tcnt == PAUSE_LAST);
    mark_end   = (st == ST_MARK) && tick && (tcnt == (enc ? ONE_LAST : ZERO_LAST));
    eof_end    = (st == ST_EOF) && pause_end;
    ks_step    = (st == ST_PAUSE) && pause_end;
    carrier_en = !((st == ST_PAUSE) || (st == ST_EOF));
    busy       = (st != ST_IDLE);
    cnt_clr    = accept || mark_end || eof_end;
    cnt_inc    = tick && (st != ST_IDLE);
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (accept)    st_nx = empty_in ? ST_EOF : ST_PAUSE;
      ST_PAUSE: if (pause_end) st_nx = ST_MARK;
      ST_MARK:  if (mark_end)  st_nx = last_bit ? ST_EOF : ST_PAUSE;
      ST_EOF:   if (eof_end)   st_nx = ST_IDLE;
      default:                 st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      enc    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= eof_end;
      if (ks_step) enc <= cur_bit ^ ks_bit;
    end
  end

  assign done = done_q;

  ppm_tick_cnt #(.W(CNT_W)) u_tick_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (tcnt)
  );

  ppm_bit_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .data_in  (frm_data),
    .len_in   (frm_len),
    .shift    (mark_end),
    .cur_bit  (cur_bit),
    .last_bit (last_bit),
    .empty_in (empty_in)
  );

  ppm_reply_timer #(.W(RPLY_W), .SATURATE(1'b1)) u_reply (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (eof_end),
    .tick  (tick),
    .cnt   (reply_ticks)
  );

  // R3: an accepted frame begins with the carrier off
  p_accept_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> (!carrier_en && busy));

  // R6: after a keystream step the carrier is back on
  p_step_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ks_step |=> carrier_en);

  // R7: the end pulse comes with the carrier on and the block idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (carrier_en && !busy));

  // R8: the reply counter is cleared in the end-pulse cycle
  p_done_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (reply_ticks == '0));

  // R10: with no tick a running frame stands still
  p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(carrier_en) && !done));

endmodule

// File: tb/ppm_frame_tx_bench.sv
module ppm_frame_tx_bench;

  localparam int DATA_W = 32;
  localparam int LEN_W  = $clog2(DATA_W) + 2;
  localparam int RPLY_W = 10;
  localparam int RMAX   = (1 << RPLY_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic frm_valid = 1'b0;
  logic [DATA_W-1:0] frm_data = '0;
  logic [LEN_W-1:0]  frm_len = '0;
  logic ks_bit;
  logic frm_ready, ks_step, carrier_en, busy, done;
  logic [RPLY_W-1:0] reply_ticks;

  always #5 clk = ~clk;

  ppm_frame_tx #(.DATA_W(DATA_W), .RPLY_W(RPLY_W)) u_ppm_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_data(frm_data), .frm_len(frm_len),
    .ks_bit(ks_bit), .ks_step(ks_step),
    .carrier_en(carrier_en), .busy(busy), .done(done),
    .reply_ticks(reply_ticks)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit timed_out = 1'b0;

  // keystream source, advanced when the design asks for it
  logic [6:0] ks_g = 7'h55;
  bit ks_adv = 1'b0;
  assign ks_bit = ks_g[0];
  always @(posedge clk) begin
    if (!rst_n) ks_g <= 7'h55;
    else if (ks_adv) ks_g <= {ks_g[5:0], ks_g[6] ^ ks_g[5]};
  end

  // tick pattern: 0 every cycle, 1 every third, 2 irregular, 3 none
  int tick_mode = 0;
  int tdiv = 0;
  logic [7:0] tl = 8'h3B;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    tl = {tl[6:0], tl[7] ^ tl[5] ^ tl[4] ^ tl[3]};
    case (tick_mode)
      0: tick <= 1'b1;
      1: tick <= (tdiv == 0);
      2: tick <= tl[0];
      default: tick <= 1'b0;
    endcase
  end

  // behavioural reference: a queue of timed carrier segments
  int  q_len[$];
  bit  q_lvl[$];
  bit  q_stp[$];
  int  m_cnt = 0;
  bit  m_done = 1'b0;
  int  m_reply = 0;

  task automatic build(input logic [DATA_W-1:0] d, input int len);
    logic [6:0] g;
    int n;
    bit e;
    g = ks_g;
    n = (len > DATA_W) ? DATA_W : len;
    for (int i = 0; i < n; i++) begin
      e = d[i] ^ g[0];
      q_len.push_back(30);  q_lvl.push_back(1'b0); q_stp.push_back(1'b1);
      q_len.push_back(e ? 120 : 60); q_lvl.push_back(1'b1); q_stp.push_back(1'b0);
      g = {g[5:0], g[6] ^ g[5]};
    end
    q_len.push_back(30); q_lvl.push_back(1'b0); q_stp.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    bit fin;
    fin = 1'b0;
    if (!rst_n) begin
      q_len.delete(); q_lvl.delete(); q_stp.delete();
      m_cnt = 0; m_done = 1'b0; m_reply = 0;
    end else begin
      if (q_len.size() > 0) begin
        if (tick) begin
          m_cnt++;
          if (m_cnt == q_len[0]) begin
            void'(q_len.pop_front()); void'(q_lvl.pop_front()); void'(q_stp.pop_front());
            m_cnt = 0;
            if (q_len.size() == 0) fin = 1'b1;
          end
        end
      end else if (frm_valid) begin
        build(frm_data, int'(frm_len));
        m_cnt = 0;
      end
      m_done = fin;
      if (fin) m_reply = 0;
      else if (tick && m_reply < RMAX) m_reply++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    bit mb, ec, es;
    #2;
    ks_adv = ks_step;
    if (rst_n) begin
      mb = (q_len.size() > 0);
      ec = mb ? q_lvl[0] : 1'b1;
      es = mb && tick && q_stp[0] && (m_cnt == q_len[0] - 1);
      chk(busy == mb, "R2 busy", busy, mb);
      chk(frm_ready == !mb, "R2 frm_ready", frm_ready, !mb);
      chk(carrier_en == ec, "R3 R4 R5 carrier_en", carrier_en, ec);
      chk(ks_step == es, "R6 ks_step", ks_step, es);
      chk(done == m_done, "R7 done", done, m_done);
      chk(int'(reply_ticks) == m_reply, "R8 reply_ticks", reply_ticks, m_reply);
    end
  end

  task automatic send(input logic [DATA_W-1:0] d, input int len, input bit hold);
    @(negedge clk);
    frm_valid <= 1'b1; frm_data <= d; frm_len <= LEN_W'(len);
    do begin
      @(negedge clk); #3;
    end while (busy == 1'b0 && frm_ready == 1'b1 && 0);
    while (!busy) begin @(negedge clk); #3; end
    if (!hold) begin frm_valid = 1'b0; frm_data = '0; end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R1: reset state
    chk(carrier_en === 1'b1, "R1 carrier_en", carrier_en, 1);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(frm_ready === 1'b1, "R1 frm_ready", frm_ready, 1);

    tick_mode = 0;
    send(32'h0000_005A, 8, 1'b0);                 // R3 R4 R5
    wait_idle();
    tick_mode = 1;
    send(32'h0000_1C3B, 13, 1'b0);                // sparse ticks
    wait_idle();
    tick_mode = 0;
    send(32'hDEAD_BEEF, 0, 1'b0);                 // R9 zero length
    wait_idle();
    tick_mode = 2;
    send(32'hFFFF_FFFF, 40, 1'b0);                // R9 clamp
    wait_idle();
    // R2: a valid raised mid-frame is ignored
    tick_mode = 0;
    send(32'h0000_0003, 4, 1'b0);
    repeat (50) @(negedge clk);
    frm_valid <= 1'b1; frm_data <= 32'h0000_0FFF; frm_len <= LEN_W'(12);
    repeat (20) @(negedge clk);
    frm_valid <= 1'b0;
    wait_idle();
    // R10: ticks stop mid-frame
    send(32'h0000_0006, 3, 1'b0);
    repeat (40) @(negedge clk);
    tick_mode = 3;
    repeat (60) @(negedge clk);
    tick_mode = 0;
    wait_idle();
    // R7 R8: back-to-back frames, acceptance on the done cycle
    send(32'h0000_0009, 5, 1'b1);
    while (!done) @(negedge clk);
    @(negedge clk); #3;
    chk(busy === 1'b1, "R7 back-to-back accept", busy, 1);
    frm_valid = 1'b0;
    wait_idle();
    // R8: saturation
    tick_mode = 0;
    repeat (RMAX + 80) @(negedge clk);
    #3;
    chk(int'(reply_ticks) == RMAX, "R8 saturation", reply_ticks, RMAX);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule